// File: doc/BRIEF.md
# Periodic Battery Test Monitor

This block checks a backup battery once per day and raises a latched low-battery warning. A one-cycle tick input that pulses once per second drives all of its timing. While main power is good, the block counts a full day of ticks. It then switches on an external test load for a fixed number of ticks and reads a comparator that flags the battery as weak. A weak reading sets the warning. The warning output models an open-drain pin: it is an active-high pull-down enable, and the pin is never driven high.

A weak result is sticky. An ordinary daily test that passes leaves the warning set. Two things clear it: a pulse on the battery-replaced strobe, or a passing result from the test that is forced after every power-up. When main power drops, the block stops its timing and keeps the warning bit. The next power-up starts the forced test. After that test, daily testing resumes from a fresh count.

Top module: `batt_test_mon`

## Requirements
- R1: While reset is held, `load_en` and `warn_pull` are both 0.
- R2: On the first clock edge where the block is unpowered and `pwr_good` is 1, a forced test starts. `load_en` is 1 from that edge on.
- R3: A test window lasts exactly WINDOW_TICKS accepted ticks. `load_en` falls on the edge that accepts the last tick of the window.
- R4: `batt_low` is sampled on the edge that accepts the last tick of the window. A value of 1 there sets `warn_pull` on that same edge.
- R5: `batt_low` has no effect on `warn_pull` at any other time, including on earlier ticks inside the window.
- R6: After a window ends, the next test starts on the edge that accepts the INTERVAL_TICKS-th tick.
- R7: A passing daily test (one not forced by power-up) leaves a set `warn_pull` unchanged.
- R8: A passing forced power-up test clears `warn_pull`.
- R9: A `batt_swap` pulse clears `warn_pull` on the next edge. The clear wins over a failing sample in the same cycle.
- R10: When `pwr_good` is 0, `load_en` is 0 from the next edge. Ticks have no effect while power is down, and `warn_pull` keeps its value. Power loss during a window aborts the window.
- R11: Clock cycles with `tick_1hz` low do not advance the interval or the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| pwr_good | input | 1 | Main supply is within tolerance |
| batt_low | input | 1 | Comparator output: 1 when the battery is below the trip level |
| batt_swap | input | 1 | Pulse when a new battery has been fitted |
| load_en | output | 1 | Connects the battery test load |
| warn_pull | output | 1 | Pull-down enable for the open-drain warning pin |

## Verification
The assertions check these rules on every cycle:
- only a window-end sample can raise the warning;
- only a swap or a passing forced test can lower it;
- a swap always clears it;
- a power loss drops the load;
- a power-up always opens a window;
- the load falls only at a sample or on a power loss.

Some behaviour needs the bench's scenarios, because it depends on exact tick counts over long stretches. These are the window and interval lengths, the fact that a daily pass leaves the warning latched, the window restarting after power loss, and the swap-over-fail priority.

// File: rtl/batt_mon_pkg.sv
package batt_mon_pkg;

  typedef enum logic [1:0] {
    MON_OFF  = 2'd0,
    MON_WAIT = 2'd1,
    MON_TEST = 2'd2
  } mon_state_e;

  // Counter width for a modulus, never below one bit.
  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  // Warning update: replacement wins, then a failing sample sets,
  // then a passing forced sample clears; otherwise hold.
  function automatic logic warn_next(input logic cur,
                                     input logic swap,
                                     input logic sample,
                                     input logic low,
                                     input logic forced);
    if (swap)             return 1'b0;
    if (sample && low)    return 1'b1;
    if (sample && forced) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int LIMIT = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  output logic wrap
);
  import batt_mon_pkg::*;

  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign wrap = adv && !clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (adv)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/test_sequencer.sv
module test_sequencer (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwr_good,
  input  logic                      tick,
  input  logic                      int_wrap,
  input  logic                      win_wrap,
  output batt_mon_pkg::mon_state_e  state,
  output logic                      int_adv,
  output logic                      int_clr,
  output logic                      win_adv,
  output logic                      win_clr,
  output logic                      sample_evt,
  output logic                      forced
);
  import batt_mon_pkg::*;

  mon_state_e state_q, state_d;
  logic       forced_q, forced_d;

  assign state      = state_q;
  assign forced     = forced_q;
  assign int_adv    = pwr_good && (state_q == MON_WAIT) && tick;
  assign win_adv    = pwr_good && (state_q == MON_TEST) && tick;
  assign int_clr    = !pwr_good || (state_q != MON_WAIT);
  assign win_clr    = !pwr_good || (state_q != MON_TEST);
  assign sample_evt = win_wrap;

  always_comb begin
    state_d  = state_q;
    forced_d = forced_q;
    if (!pwr_good) begin
      state_d = MON_OFF;
    end else begin
      unique case (state_q)
        MON_OFF: begin
          state_d  = MON_TEST;
          forced_d = 1'b1;
        end
        MON_WAIT: if (int_wrap) begin
          state_d  = MON_TEST;
          forced_d = 1'b0;
        end
        MON_TEST: if (win_wrap) state_d = MON_WAIT;
        default:  state_d = MON_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= MON_OFF;
      forced_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      forced_q <= forced_d;
    end
  end

endmodule

// File: rtl/warn_latch.sv
module warn_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic swap,
  input  logic sample,
  input  logic low,
  input  logic forced,
  output logic warn
);
  import batt_mon_pkg::*;

  logic warn_q;

  assign warn = warn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_next(warn_q, swap, sample, low, forced);
  end

endmodule

// File: rtl/batt_test_mon.sv
module batt_test_mon #(
  parameter int INTERVAL_TICKS = 86400,
  parameter int WINDOW_TICKS   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic pwr_good,
  input  logic batt_low,
  input  logic batt_swap,
  output logic load_en,
  output logic warn_pull
);
  import batt_mon_pkg::*;

  mon_state_e state;
  logic int_adv, int_clr, int_wrap;
  logic win_adv, win_clr, win_wrap;
  logic sample_evt, forced_test, mon_off;

  tick_counter #(.LIMIT(INTERVAL_TICKS)) u_interval (
    .clk(clk), .rst_n(rst_n), .clear(int_clr), .adv(int_adv), .wrap(int_wrap)
  );

  tick_counter #(.LIMIT(WINDOW_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(win_clr), .adv(win_adv), .wrap(win_wrap)
  );

  test_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tick(tick_1hz),
    .int_wrap(int_wrap), .win_wrap(win_wrap), .state(state),
    .int_adv(int_adv), .int_clr(int_clr), .win_adv(win_adv),
    .win_clr(win_clr), .sample_evt(sample_evt), .forced(forced_test)
  );

  warn_latch u_warn (
    .clk(clk), .rst_n(rst_n), .swap(batt_swap), .sample(sample_evt),
    .low(batt_low), .forced(forced_test), .warn(warn_pull)
  );

  assign mon_off = (state == MON_OFF);
  assign load_en = (state == MON_TEST);

endmodule

// File: rtl/batt_test_mon_chk.sv
module batt_test_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic batt_low,
  input logic batt_swap,
  input logic load_en,
  input logic warn_pull,
  input logic sample_evt,
  input logic forced_test,
  input logic mon_off
);

  p_powerup_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_off && pwr_good) |=> load_en);

  p_load_end_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_en) |-> ($past(sample_evt) || !$past(pwr_good)));

  p_warn_rise_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_pull) |-> ($past(sample_evt) && $past(batt_low)));

  p_sample_ends_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> !load_en);

  p_warn_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_pull) |->
      ($past(batt_swap) || ($past(sample_evt) && $past(forced_test) && !$past(batt_low))));

  p_swap_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    batt_swap |=> !warn_pull);

  p_no_load_unpowered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !load_en);

endmodule

bind batt_test_mon batt_test_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .batt_low(batt_low),
  .batt_swap(batt_swap), .load_en(load_en), .warn_pull(warn_pull),
  .sample_evt(sample_evt), .forced_test(forced_test), .mon_off(mon_off)
);

// File: tb/tb_batt_test_mon.sv
`timescale 1ns/1ps
module tb_batt_test_mon;
  localparam int IVL = 5;
  localparam int WIN = 3;

  logic clk = 1'b0;
  logic rst_n, tick_1hz, pwr_good, batt_low, batt_swap;
  logic load_en, warn_pull;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  batt_test_mon #(.INTERVAL_TICKS(IVL), .WINDOW_TICKS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_good(pwr_good),
    .batt_low(batt_low), .batt_swap(batt_swap),
    .load_en(load_en), .warn_pull(warn_pull)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_load, input logic exp_warn);
    chk(req, "load_en", load_en, exp_load);
    chk(req, "warn_pull", warn_pull, exp_warn);
  endtask

  // One accepted tick; returns at the negedge after the accepting edge.
  task automatic tick_once();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count a whole interval; the last tick must open the window (R6).
  task automatic run_interval(input logic exp_warn);
    for (int i = 0; i < IVL - 1; i++) begin
      tick_once();
      chk("R6", "load before interval end", load_en, 1'b0);
    end
    tick_once();
    chk_out("R6", 1'b1, exp_warn);
  endtask

  // Run a window; batt_low is 1 on early ticks (R5), last_low on the last.
  task automatic run_window(input logic last_low, input logic warn_before, input logic exp_warn);
    for (int i = 0; i < WIN - 1; i++) begin
      batt_low = 1'b1;
      tick_once();
      chk_out("R5", 1'b1, warn_before);
    end
    batt_low = last_low;
    tick_once();
    batt_low = 1'b0;
    chk_out("R4", 1'b0, exp_warn);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick_1hz = 1'b0; pwr_good = 1'b0; batt_low = 1'b0; batt_swap = 1'b0;
    idle(4);
    chk_out("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    tick_once();
    idle(2);
    chk_out("R10", 1'b0, 1'b0);
  endtask

  task automatic t_powerup_pass();
    pwr_good = 1'b1;
    @(negedge clk);
    chk_out("R2", 1'b1, 1'b0);
    run_window(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_interval_idle();
    for (int i = 0; i < IVL - 1; i++) begin
      tick_once();
      idle(3);
      chk("R11", "load during idle cycles", load_en, 1'b0);
    end
    tick_once();
    chk_out("R6", 1'b1, 1'b0);
    run_window(1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_latched();
    run_interval(1'b1);
    run_window(1'b0, 1'b1, 1'b1);
    chk("R7", "warn after daily pass", warn_pull, 1'b1);
  endtask

  task automatic t_power_cycle();
    tick_once(); tick_once();
    pwr_good = 1'b0;
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b1);
    for (int i = 0; i < 2 * IVL; i++) tick_once();
    chk_out("R10", 1'b0, 1'b1);
    pwr_good = 1'b1;
    @(negedge clk);
    chk_out("R2", 1'b1, 1'b1);
    run_window(1'b0, 1'b1, 1'b0);
    chk("R8", "warn after forced pass", warn_pull, 1'b0);
  endtask

  task automatic t_swap();
    run_interval(1'b0);
    run_window(1'b1, 1'b0, 1'b1);
    @(negedge clk) batt_swap = 1'b1;
    @(negedge clk) batt_swap = 1'b0;
    chk("R9", "warn after swap", warn_pull, 1'b0);
  endtask

  task automatic t_swap_priority();
    run_interval(1'b0);
    for (int i = 0; i < WIN - 1; i++) tick_once();
    batt_low = 1'b1; batt_swap = 1'b1;
    tick_once();
    batt_low = 1'b0; batt_swap = 1'b0;
    chk_out("R9", 1'b0, 1'b0);
  endtask

  task automatic t_fail_in_window();
    run_interval(1'b0);
    tick_once();
    pwr_good = 1'b0;
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk_out("R2", 1'b1, 1'b0);
    for (int i = 0; i < WIN - 1; i++) begin
      tick_once();
      chk("R3", "window restarted, still loading", load_en, 1'b1);
    end
    tick_once();
    chk("R3", "load after full window", load_en, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup_pass();
    t_interval_idle();
    t_latched();
    t_power_cycle();
    t_swap();
    t_swap_priority();
    t_fail_in_window();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule